// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the instruction fetch address for a small 8-bit core that keeps program and data storage on separate buses. A 21-bit counter addresses program memory one 16-bit word at a time. On each fetch strobe the counter moves to the next word, loads a jump or call target, restores a saved address, or enters an interrupt routine. Saved addresses live in a 31-entry last-in-first-out stack that is shared by subroutine calls and interrupt entry.

Fetch and execute overlap. While the decoder executes one instruction, the word at the current fetch address is already on its way. Any change of flow therefore also raises a bubble flag for one fetch, and the core then discards that word as a no-op. A push into a full stack or a pop from an empty stack does not move the counter. It sets a sticky fault flag instead.

Top module: `pc_sequencer`

## Requirements
- R1: When `fetch_en` is high, no interrupt is requested and `cmd` is 0 (step), `fetch_addr` increases by one after the clock edge. The count wraps from 0x1FFFFF to 0x000000.
- R2: When `rst` is high, `fetch_addr` becomes 0x000000 on the next edge. In the same edge the stack empties (`stk_empty`=1, `stk_full`=0) and `bubble`, `stk_ovf` and `stk_unf` clear.
- R3: When `fetch_en` is high, `irq_hi` loads 0x000008 and `irq_lo` loads 0x000018. If both are requested, `irq_hi` wins. Either request overrides `cmd`.
- R4: `cmd`=2 (call) pushes the current `fetch_addr`, which is the word after the call, and then loads `target`. `cmd`=1 (jump) loads `target` and does not touch the stack.
- R5: `cmd`=3 (return) loads the most recently pushed address and removes it from the stack. Nested calls therefore unwind in reverse order.
- R6: Interrupt entry pushes the current `fetch_addr` before it vectors. A later return restores that address.
- R7: Every taken jump, call, return or interrupt entry sets `bubble` to 1, together with the new `fetch_addr`. A step clears `bubble`.
- R8: While `fetch_en` is low, `cmd`, `target` and both interrupt requests are ignored. `fetch_addr`, `bubble` and the stack stay unchanged.
- R9: A call or interrupt entry while `stk_full`=1 (31 entries held) sets sticky `stk_ovf`. It leaves `fetch_addr` and the stack contents unchanged and does not raise `bubble`.
- R10: A return while `stk_empty`=1 sets sticky `stk_unf`. It leaves `fetch_addr` unchanged and does not raise `bubble`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Fetch strobe; the sequencer acts only when this is high |
| cmd | input | 2 | Flow command: 0 step, 1 jump, 2 call, 3 return |
| target | input | 21 | Jump or call destination word address |
| irq_hi | input | 1 | High-priority interrupt request |
| irq_lo | input | 1 | Low-priority interrupt request |
| fetch_addr | output | 21 | Registered program memory word address |
| bubble | output | 1 | The word fetched at this address follows a flow change; the core treats the discarded prefetch as a no-op |
| stk_full | output | 1 | Return stack holds 31 entries |
| stk_empty | output | 1 | Return stack holds no entries |
| stk_ovf | output | 1 | Sticky: a push was attempted into a full stack |
| stk_unf | output | 1 | Sticky: a pop was attempted from an empty stack |

## Verification
The assertions check on every cycle the single-step advance and its wrap, both interrupt vectors with high-priority precedence, freezing while the strobe is low, and the fault behaviour on a full or empty stack. They cannot see stored return addresses, so last-in-first-out ordering, the exact address saved by a call or an interrupt, and interleaved call/interrupt/return chains are shown only by the bench's scenarios. The bench fills the stack to 31 entries, overflows it, and then confirms that the top entry survived.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam logic [1:0] CMD_STEP = 2'd0;
  localparam logic [1:0] CMD_JUMP = 2'd1;
  localparam logic [1:0] CMD_CALL = 2'd2;
  localparam logic [1:0] CMD_RET  = 2'd3;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_STEP,
    ACT_LOAD_TGT,
    ACT_LOAD_HI,
    ACT_LOAD_LO,
    ACT_POP,
    ACT_FAULT_OVF,
    ACT_FAULT_UNF
  } flow_act_e;
endpackage

// File: rtl/pc_flow_arb.sv
module pc_flow_arb
  import pc_seq_pkg::*;
(
  input  logic       fetch_en,
  input  logic [1:0] cmd,
  input  logic       irq_hi,
  input  logic       irq_lo,
  input  logic       full,
  input  logic       empty,
  output flow_act_e  act,
  output logic       push,
  output logic       pop
);
  always_comb begin
    act  = ACT_HOLD;
    push = 1'b0;
    pop  = 1'b0;
    if (fetch_en) begin
      if (irq_hi || irq_lo) begin
        if (full) begin
          act = ACT_FAULT_OVF;
        end else begin
          act  = irq_hi ? ACT_LOAD_HI : ACT_LOAD_LO;
          push = 1'b1;
        end
      end else begin
        case (cmd)
          CMD_STEP: act = ACT_STEP;
          CMD_JUMP: act = ACT_LOAD_TGT;
          CMD_CALL: begin
            if (full) act = ACT_FAULT_OVF;
            else begin
              act  = ACT_LOAD_TGT;
              push = 1'b1;
            end
          end
          default: begin
            if (empty) act = ACT_FAULT_UNF;
            else begin
              act = ACT_POP;
              pop = 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int W     = 21,
  parameter int DEPTH = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [IW-1:0]  top_idx;
  logic [IW-1:0]  wr_idx;

  assign full    = (sp == SPW'(DEPTH));
  assign empty   = (sp == '0);
  assign top_idx = empty ? '0 : IW'(sp - 1'b1);
  assign wr_idx  = full ? '0 : IW'(sp);
  assign rdata   = mem[top_idx];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && !full) begin
      sp <= sp + 1'b1;
    end else if (pop && !empty) begin
      sp <= sp - 1'b1;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int          ADDR_W   = 21,
  parameter int          STK_DEPTH = 31,
  parameter logic [20:0] RST_VEC  = 21'h000000,
  parameter logic [20:0] HI_VEC   = 21'h000008,
  parameter logic [20:0] LO_VEC   = 21'h000018
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_en,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] target,
  input  logic              irq_hi,
  input  logic              irq_lo,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              bubble,
  output logic              stk_full,
  output logic              stk_empty,
  output logic              stk_ovf,
  output logic              stk_unf
);
  flow_act_e         act;
  logic              push, pop;
  logic [ADDR_W-1:0] stk_top;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              bub_q, bub_d;
  logic              ovf_q, unf_q;

  pc_flow_arb u_arb (
    .fetch_en (fetch_en),
    .cmd      (cmd),
    .irq_hi   (irq_hi),
    .irq_lo   (irq_lo),
    .full     (stk_full),
    .empty    (stk_empty),
    .act      (act),
    .push     (push),
    .pop      (pop)
  );

  pc_ret_stack #(.W(ADDR_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .wdata (pc_q),
    .rdata (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_comb begin
    pc_d  = pc_q;
    bub_d = bub_q;
    case (act)
      ACT_STEP:      begin pc_d = pc_q + 1'b1;          bub_d = 1'b0; end
      ACT_LOAD_TGT:  begin pc_d = target;               bub_d = 1'b1; end
      ACT_LOAD_HI:   begin pc_d = ADDR_W'(HI_VEC);      bub_d = 1'b1; end
      ACT_LOAD_LO:   begin pc_d = ADDR_W'(LO_VEC);      bub_d = 1'b1; end
      ACT_POP:       begin pc_d = stk_top;              bub_d = 1'b1; end
      ACT_FAULT_OVF,
      ACT_FAULT_UNF: bub_d = 1'b0;
      default:       ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= ADDR_W'(RST_VEC);
      bub_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      bub_q <= bub_d;
      if (act == ACT_FAULT_OVF) ovf_q <= 1'b1;
      if (act == ACT_FAULT_UNF) unf_q <= 1'b1;
    end
  end

  assign fetch_addr = pc_q;
  assign bubble     = bub_q;
  assign stk_ovf    = ovf_q;
  assign stk_unf    = unf_q;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int          ADDR_W = 21,
  parameter logic [20:0] HI_VEC = 21'h000008,
  parameter logic [20:0] LO_VEC = 21'h000018
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_en,
  input logic [1:0]        cmd,
  input logic              irq_hi,
  input logic              irq_lo,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              bubble,
  input logic              stk_full,
  input logic              stk_empty,
  input logic              stk_ovf,
  input logic              stk_unf
);
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && !irq_hi && !irq_lo && cmd == 2'd0)
      |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)) && !bubble);

  a_r3_hi_vector: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && irq_hi && !stk_full)
      |=> (fetch_addr == ADDR_W'(HI_VEC)) && bubble);

  a_r3_lo_vector: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && !irq_hi && irq_lo && !stk_full)
      |=> (fetch_addr == ADDR_W'(LO_VEC)) && bubble);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> $stable(fetch_addr) && $stable(bubble) && $stable(stk_empty) && $stable(stk_full));

  a_r9_overflow: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && stk_full && (irq_hi || irq_lo || cmd == 2'd2))
      |=> stk_ovf && stk_full && $stable(fetch_addr) && !bubble);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);

  a_r10_underflow: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && stk_empty && !irq_hi && !irq_lo && cmd == 2'd3)
      |=> stk_unf && $stable(fetch_addr) && !bubble);

  a_r2_status_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(stk_full && stk_empty));
endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W (ADDR_W),
  .HI_VEC (HI_VEC),
  .LO_VEC (LO_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_en   (fetch_en),
  .cmd        (cmd),
  .irq_hi     (irq_hi),
  .irq_lo     (irq_lo),
  .fetch_addr (fetch_addr),
  .bubble     (bubble),
  .stk_full   (stk_full),
  .stk_empty  (stk_empty),
  .stk_ovf    (stk_ovf),
  .stk_unf    (stk_unf)
);

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [20:0] target = '0;
  logic        irq_hi = 1'b0;
  logic        irq_lo = 1'b0;
  logic [20:0] fetch_addr;
  logic        bubble, stk_full, stk_empty, stk_ovf, stk_unf;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .cmd(cmd), .target(target),
    .irq_hi(irq_hi), .irq_lo(irq_lo), .fetch_addr(fetch_addr), .bubble(bubble),
    .stk_full(stk_full), .stk_empty(stk_empty), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  function automatic logic [48:0] v(input logic en, input logic [1:0] c,
                                    input logic h, input logic l,
                                    input logic [20:0] t, input logic [20:0] e,
                                    input logic b, input logic m);
    return {en, c, h, l, t, e, b, m};
  endfunction

  // columns: en, cmd, irq_hi, irq_lo, target, expected addr, expected bubble, expected empty
  localparam int NV = 18;
  localparam logic [48:0] TBL [NV] = '{
    v(1, 2'd0, 0, 0, 21'h0,     21'h000001, 0, 1), // R1 step
    v(1, 2'd0, 0, 0, 21'h0,     21'h000002, 0, 1), // R1 step
    v(0, 2'd1, 1, 0, 21'h55,    21'h000002, 0, 1), // R8 idle ignores jump and irq
    v(1, 2'd1, 0, 0, 21'h100,   21'h000100, 1, 1), // R4 jump, R7 bubble
    v(1, 2'd0, 0, 0, 21'h0,     21'h000101, 0, 1), // R7 bubble clears
    v(1, 2'd2, 0, 0, 21'h200,   21'h000200, 1, 0), // R4 call pushes 0x101
    v(1, 2'd0, 0, 0, 21'h0,     21'h000201, 0, 0),
    v(1, 2'd2, 0, 0, 21'h300,   21'h000300, 1, 0), // R4 nested call pushes 0x201
    v(1, 2'd3, 0, 0, 21'h0,     21'h000201, 1, 0), // R5 return
    v(1, 2'd0, 0, 0, 21'h0,     21'h000202, 0, 0),
    v(1, 2'd3, 0, 0, 21'h0,     21'h000101, 1, 1), // R5 LIFO unwind
    v(1, 2'd0, 0, 1, 21'h0,     21'h000018, 1, 0), // R3 low vector, R6 push 0x101
    v(1, 2'd0, 0, 0, 21'h0,     21'h000019, 0, 0),
    v(1, 2'd0, 1, 0, 21'h0,     21'h000008, 1, 0), // R3 high vector, R6 push 0x19
    v(1, 2'd3, 0, 0, 21'h0,     21'h000019, 1, 0), // R6 restore
    v(1, 2'd1, 1, 1, 21'h777,   21'h000008, 1, 0), // R3 high wins over low and jump
    v(1, 2'd3, 0, 0, 21'h0,     21'h000019, 1, 0), // R6 restore
    v(1, 2'd3, 0, 0, 21'h0,     21'h000101, 1, 1)  // R6 restore outer
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [1:0] c, input logic h,
                      input logic l, input logic [20:0] t);
    fetch_en = en; cmd = c; irq_hi = h; irq_lo = l; target = t;
    @(negedge clk);
    fetch_en = 1'b0; irq_hi = 1'b0; irq_lo = 1'b0; cmd = 2'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R2 reset addr", 32'(fetch_addr), 32'h0);
    chk("R2 reset empty", 32'(stk_empty), 32'h1);
    chk("R2 reset full", 32'(stk_full), 32'h0);
    chk("R2 reset bubble", 32'(bubble), 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][48], TBL[i][47:46], TBL[i][45], TBL[i][44], TBL[i][43:23]);
      chk($sformatf("R1-table row %0d addr", i), 32'(fetch_addr), 32'(TBL[i][22:2]));
      chk($sformatf("R7 row %0d bubble", i), 32'(bubble), 32'(TBL[i][1]));
      chk($sformatf("R5 row %0d empty", i), 32'(stk_empty), 32'(TBL[i][0]));
    end

    // R10: return from empty stack
    step(1, 2'd3, 0, 0, 21'h0);
    chk("R10 underflow addr held", 32'(fetch_addr), 32'h101);
    chk("R10 underflow flag", 32'(stk_unf), 32'h1);
    chk("R10 underflow no bubble", 32'(bubble), 32'h0);
    chk("R10 no overflow", 32'(stk_ovf), 32'h0);

    // R1: wrap at the top of the address space
    step(1, 2'd1, 0, 0, 21'h1FFFFF);
    chk("R1 jump to top", 32'(fetch_addr), 32'h1FFFFF);
    step(1, 2'd0, 0, 0, 21'h0);
    chk("R1 wrap to zero", 32'(fetch_addr), 32'h0);

    // R9: fill the stack to 31 entries, then overflow
    for (int i = 0; i < 31; i++) step(1, 2'd2, 0, 0, 21'(32'h1000 + i));
    chk("R9 full after 31 calls", 32'(stk_full), 32'h1);
    chk("R9 addr after 31 calls", 32'(fetch_addr), 32'h101E);
    step(1, 2'd2, 0, 0, 21'h5000);
    chk("R9 call overflow addr held", 32'(fetch_addr), 32'h101E);
    chk("R9 overflow flag", 32'(stk_ovf), 32'h1);
    chk("R9 overflow no bubble", 32'(bubble), 32'h0);
    step(1, 2'd0, 1, 0, 21'h0);
    chk("R9 irq overflow addr held", 32'(fetch_addr), 32'h101E);
    step(1, 2'd3, 0, 0, 21'h0);
    chk("R9 top entry intact", 32'(fetch_addr), 32'h101D);
    chk("R9 not full after pop", 32'(stk_full), 32'h0);

    // R2: reset clears flags and stack mid-run
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R2 rerun addr", 32'(fetch_addr), 32'h0);
    chk("R2 rerun ovf", 32'(stk_ovf), 32'h0);
    chk("R2 rerun unf", 32'(stk_unf), 32'h0);
    chk("R2 rerun empty", 32'(stk_empty), 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule